// File: doc/BRIEF.md
# Indexed Timekeeper Register File with Interrupt Flags

This block is the host-facing register file of a real-time clock. A host reaches a 128-byte register space through two addresses: the even address holds an index pointer and the odd address reads or writes the byte that the pointer selects. The space holds the seven time fields, three alarm bytes, four control and status bytes, and general storage. The calendar arithmetic sits outside the block: it presents the next time fields on an input bus, already in the encoding selected by the control bits, and the block copies them into the time bytes at the end of each one-second update.

The block runs the update sequence. A one-second tick opens a busy window of `UIP_CYCLES` clock cycles, shown as a read-only busy bit in control byte A. When the window closes, the time is copied, the alarm comparison is made and the update-ended event is raised. A separate periodic rate generator takes its rate and enables from configuration outputs and returns a pulse, which is merged into the flag byte here. One level interrupt line stays high while any enabled event is pending. Reading the flag byte returns the flags, clears them and drops the line.

Top module: `timekeeper_regfile`

## Requirements
- R1: A write to the even address (host_sel=0) loads the index pointer from bits 6:0 of the write data, and bit 7 is discarded. A read of the even address returns 0xFF.
- R2: The odd address (host_sel=1) reads and writes the byte at the index pointer. The alarm bytes (indices 1, 3, 5) and the general bytes (indices 14 to 127) keep what was written.
- R3: After reset, control byte A (index 10) reads 0x26, B (index 11) reads 0x02, the flag byte (index 12) reads 0x00, status byte D (index 13) reads 0x80, and irq_o is low. irq_o is never high while flag bit 7 is clear.
- R4: Bit 7 of A ignores host writes and keeps its value. Host writes to the flag byte and to byte D have no effect.
- R5: A read of the flag byte returns its current value. At that clock edge the byte clears to 0x00 and irq_o goes low, unless a new event arrives in the same cycle.
- R6: A write to B with bit 7 (hold) set clears the busy bit of A at once and stores bit 4 (update-ended enable) as 0.
- R7: A tick while A bits 6:4 equal 010 sets the busy bit for exactly UIP_CYCLES cycles, or leaves it clear if B bit 7 is set. For any other value of A bits 6:4 the tick is ignored. Ticks that arrive during the window are ignored.
- R8: When the window closes with B bit 7 clear, the presented time fields are copied to indices 0 (seconds), 2 (minutes), 4 (hours), 6 (weekday), 7 (day), 8 (month) and 9 (year). With B bit 7 set, nothing is copied.
- R9: When the window closes with B bit 5 set, the alarm fires if each alarm byte (1 for seconds, 3 for minutes, 5 for hours) either has bits 7:6 both set or equals the presented field. Firing sets flag bits 7 and 5 and raises irq_o.
- R10: When the window closes with B bit 4 set, flag bits 7 and 4 are set and irq_o is raised.
- R11: A periodic pulse sets flag bits 7 and 6 and raises irq_o when B bit 6 is set. Without that bit the pulse has no effect.
- R12: If an event arrives in the same cycle as a flag-byte read, the read returns the old value, the new event's bits stay set afterwards, and irq_o stays high.
- R13: cfg_rate shows A bits 3:0. cfg_per_en, cfg_sqw_en, cfg_bin_mode and cfg_24h show B bits 6, 3, 2 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | 0 selects the index pointer, 1 selects the indexed byte |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle; read data is valid in the same cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data |
| sec_tick | input | 1 | One-second tick pulse |
| per_pulse | input | 1 | Pulse from the periodic rate generator |
| cal_sec | input | 8 | Presented seconds field |
| cal_min | input | 8 | Presented minutes field |
| cal_hour | input | 8 | Presented hours field |
| cal_wday | input | 8 | Presented weekday field |
| cal_mday | input | 8 | Presented day-of-month field |
| cal_mon | input | 8 | Presented month field |
| cal_year | input | 8 | Presented year field |
| irq_o | output | 1 | Level interrupt |
| cfg_rate | output | 4 | Periodic rate select |
| cfg_per_en | output | 1 | Periodic interrupt enable |
| cfg_sqw_en | output | 1 | Square-wave enable |
| cfg_bin_mode | output | 1 | Binary (1) or BCD (0) encoding |
| cfg_24h | output | 1 | 24-hour mode |

## Verification
A flag-byte read clears the byte, and in the same clock cycle an event may try to set flag bits. This can happen at the close of an update window or on a periodic pulse. The bench provokes the collision directly: with the index already on the flag byte, it asserts the periodic pulse and the read strobe in the same cycle. The read must return the old value (0x00). The line must stay high after that edge, and a second read must return 0xC0. A busy-bit write through byte B can also meet the start of a window. The bench checks this by writing hold mode while the window is open, then confirming that the busy bit is clear and that no time copy happens when the window closes.

// File: rtl/tkr_pkg.sv
package tkr_pkg;
  // byte indices whose positions other logic decodes
  localparam int IX_SEC     = 0;
  localparam int IX_SEC_AL  = 1;
  localparam int IX_MIN     = 2;
  localparam int IX_MIN_AL  = 3;
  localparam int IX_HOUR    = 4;
  localparam int IX_HOUR_AL = 5;
  localparam int IX_WDAY    = 6;
  localparam int IX_MDAY    = 7;
  localparam int IX_MON     = 8;
  localparam int IX_YEAR    = 9;
  localparam int IX_CTLA    = 10;
  localparam int IX_CTLB    = 11;
  localparam int IX_FLAG    = 12;
  localparam int IX_STAT    = 13;

  localparam int NTIME   = 7;
  localparam int NALARM  = 3;

  // control A
  localparam int A_BUSY  = 7;
  localparam logic [2:0] OSC_RUN = 3'b010;
  // control B
  localparam int B_HOLD  = 7;
  localparam int B_PER   = 6;
  localparam int B_ALM   = 5;
  localparam int B_UPD   = 4;
  localparam int B_SQW   = 3;
  localparam int B_BIN   = 2;
  localparam int B_24H   = 1;
  // flag byte
  localparam int F_ANY   = 7;
  localparam int F_PER   = 6;
  localparam int F_ALM   = 5;
  localparam int F_UPD   = 4;

  // k-th time field -> byte index
  function automatic int time_slot(input int k);
    case (k)
      0:       return IX_SEC;
      1:       return IX_MIN;
      2:       return IX_HOUR;
      3:       return IX_WDAY;
      4:       return IX_MDAY;
      5:       return IX_MON;
      default: return IX_YEAR;
    endcase
  endfunction

  function automatic logic [7:0] rst_byte(input int ix);
    case (ix)
      IX_CTLA: return 8'h26;
      IX_CTLB: return 8'h02;
      IX_STAT: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tkr_index_port.sv
module tkr_index_port #(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sel,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [DW-1:0]    host_wdata,
  output logic [IDX_W-1:0] idx_q,
  output logic             data_wr,
  output logic             data_rd
);
  logic             idx_en;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_en  = host_wr && !host_sel;
    idx_d   = host_wdata[IDX_W-1:0];
    data_wr = host_wr && host_sel;
    data_rd = host_rd && host_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_sel) |=> (idx_q == $past(host_wdata[IDX_W-1:0])));
endmodule

// File: rtl/tkr_update_seq.sv
module tkr_update_seq #(
  parameter int unsigned CYCLES = 24400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic osc_ok,
  output logic start,
  output logic done,
  output logic busy
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          seq_en;

  always_comb begin
    start  = tick && osc_ok && !busy_q;
    done   = busy_q && (cnt_q == '0);
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = LAST;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
    end
    seq_en = start || busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (seq_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

  // R7
  win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R7
  win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
endmodule

// File: rtl/tkr_alarm_match.sv
module tkr_alarm_match #(
  parameter int unsigned DW = 8,
  parameter int unsigned NF = 3
) (
  input  logic [NF-1:0][DW-1:0] alarm_b,
  input  logic [NF-1:0][DW-1:0] now_b,
  output logic                  hit
);
  logic [NF-1:0] fld_ok;

  for (genvar k = 0; k < NF; k++) begin : g_fld
    assign fld_ok[k] = (&alarm_b[k][DW-1:DW-2]) || (alarm_b[k] == now_b[k]);
  end

  assign hit = &fld_ok;
endmodule

// File: rtl/timekeeper_regfile.sv
module timekeeper_regfile
  import tkr_pkg::*;
#(
  parameter int unsigned IDX_W      = 7,
  parameter int unsigned DW         = 8,
  parameter int unsigned UIP_CYCLES = 24400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          sec_tick,
  input  logic          per_pulse,
  input  logic [DW-1:0] cal_sec,
  input  logic [DW-1:0] cal_min,
  input  logic [DW-1:0] cal_hour,
  input  logic [DW-1:0] cal_wday,
  input  logic [DW-1:0] cal_mday,
  input  logic [DW-1:0] cal_mon,
  input  logic [DW-1:0] cal_year,
  output logic          irq_o,
  output logic [3:0]    cfg_rate,
  output logic          cfg_per_en,
  output logic          cfg_sqw_en,
  output logic          cfg_bin_mode,
  output logic          cfg_24h
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DW-1:0]    mem_q [DEPTH];
  logic [DW-1:0]    mem_d [DEPTH];
  logic [DEPTH-1:0] mem_en;

  logic [IDX_W-1:0] idx_q;
  logic             data_wr, data_rd;
  logic             upd_start, upd_done, upd_busy;
  logic             alarm_hit;
  logic             osc_ok;
  logic [NTIME-1:0][DW-1:0]  now_f;
  logic [NALARM-1:0][DW-1:0] alarm_b, alarm_now;
  logic [DW-1:0]    ctl_a, ctl_b, flag_q;
  logic [DW-1:0]    flag_set;
  logic             c_clear;
  logic             busy_d;
  logic             irq_q, irq_d;

  tkr_index_port #(.IDX_W(IDX_W), .DW(DW)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .idx_q      (idx_q),
    .data_wr    (data_wr),
    .data_rd    (data_rd)
  );

  assign ctl_a  = mem_q[IX_CTLA];
  assign ctl_b  = mem_q[IX_CTLB];
  assign flag_q = mem_q[IX_FLAG];
  assign osc_ok = (ctl_a[6:4] == OSC_RUN);

  tkr_update_seq #(.CYCLES(UIP_CYCLES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (sec_tick),
    .osc_ok (osc_ok),
    .start  (upd_start),
    .done   (upd_done),
    .busy   (upd_busy)
  );

  assign now_f = {cal_year, cal_mon, cal_mday, cal_wday, cal_hour, cal_min, cal_sec};
  assign alarm_b   = {mem_q[IX_HOUR_AL], mem_q[IX_MIN_AL], mem_q[IX_SEC_AL]};
  assign alarm_now = {cal_hour, cal_min, cal_sec};

  tkr_alarm_match #(.DW(DW), .NF(NALARM)) u_alarm (
    .alarm_b (alarm_b),
    .now_b   (alarm_now),
    .hit     (alarm_hit)
  );

  // event merge
  always_comb begin
    flag_set = '0;
    if (per_pulse && ctl_b[B_PER]) begin
      flag_set[F_ANY] = 1'b1;
      flag_set[F_PER] = 1'b1;
    end
    if (upd_done && ctl_b[B_ALM] && alarm_hit) begin
      flag_set[F_ANY] = 1'b1;
      flag_set[F_ALM] = 1'b1;
    end
    if (upd_done && ctl_b[B_UPD]) begin
      flag_set[F_ANY] = 1'b1;
      flag_set[F_UPD] = 1'b1;
    end
    c_clear = data_rd && (idx_q == IDX_W'(IX_FLAG));
    irq_d   = (irq_q && !c_clear) || flag_set[F_ANY];
  end

  // busy bit
  always_comb begin
    busy_d = ctl_a[A_BUSY];
    if (upd_start && !ctl_b[B_HOLD]) busy_d = 1'b1;
    if (upd_done) busy_d = 1'b0;
    if (data_wr && (idx_q == IDX_W'(IX_CTLB)) && host_wdata[B_HOLD]) busy_d = 1'b0;
  end

  // register space next state
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i]  = mem_q[i];
      mem_en[i] = 1'b0;
    end
    if (data_wr) begin
      case (int'(idx_q))
        IX_CTLA: begin
          mem_d[IX_CTLA][6:0] = host_wdata[6:0];
          mem_en[IX_CTLA]     = 1'b1;
        end
        IX_CTLB: begin
          mem_d[IX_CTLB] = host_wdata;
          if (host_wdata[B_HOLD]) mem_d[IX_CTLB][B_UPD] = 1'b0;
          mem_en[IX_CTLB] = 1'b1;
        end
        IX_FLAG, IX_STAT: ;
        default: begin
          mem_d[idx_q]  = host_wdata;
          mem_en[idx_q] = 1'b1;
        end
      endcase
    end
    if (upd_done && !ctl_b[B_HOLD]) begin
      for (int k = 0; k < NTIME; k++) begin
        mem_d[time_slot(k)]  = now_f[k];
        mem_en[time_slot(k)] = 1'b1;
      end
    end
    mem_d[IX_CTLA][A_BUSY] = busy_d;
    if (busy_d != ctl_a[A_BUSY]) mem_en[IX_CTLA] = 1'b1;
    mem_d[IX_FLAG]  = (c_clear ? '0 : flag_q) | flag_set;
    mem_en[IX_FLAG] = c_clear || (|flag_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(rst_byte(i));
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (mem_en[i]) mem_q[i] <= mem_d[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (c_clear || flag_set[F_ANY]) begin
      irq_q <= irq_d;
    end
  end

  assign irq_o        = irq_q;
  assign host_rdata   = host_sel ? mem_q[idx_q] : {DW{1'b1}};
  assign cfg_rate     = ctl_a[3:0];
  assign cfg_per_en   = ctl_b[B_PER];
  assign cfg_sqw_en   = ctl_b[B_SQW];
  assign cfg_bin_mode = ctl_b[B_BIN];
  assign cfg_24h      = ctl_b[B_24H];

  // R3
  irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_q[F_ANY]);
  // R4
  stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_q == IDX_W'(IX_STAT)) |=> $stable(mem_q[IX_STAT]));
  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_clear && flag_set == '0) |=> (!irq_o && flag_q == '0));
  // R6
  hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_q == IDX_W'(IX_CTLB) && host_wdata[B_HOLD])
      |=> (!ctl_a[A_BUSY] && !ctl_b[B_UPD]));
  // R10
  upd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && ctl_b[B_UPD]) |=> (irq_o && flag_q[F_ANY] && flag_q[F_UPD]));
  // R12
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_clear && flag_set[F_ANY]) |=> irq_o);
endmodule

// File: tb/timekeeper_regfile_tb_top.sv
module timekeeper_regfile_tb_top;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       sec_tick = 1'b0, per_pulse = 1'b0;
  logic [7:0] cal_sec = 8'h30, cal_min = 8'h45, cal_hour = 8'h12;
  logic [7:0] cal_wday = 8'h03, cal_mday = 8'h21, cal_mon = 8'h06, cal_year = 8'h24;
  logic       irq_o, cfg_per_en, cfg_sqw_en, cfg_bin_mode, cfg_24h;
  logic [3:0] cfg_rate;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] mirror [128];

  always #5 clk = ~clk;

  timekeeper_regfile #(.UIP_CYCLES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sec_tick(sec_tick), .per_pulse(per_pulse),
    .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
    .cal_wday(cal_wday), .cal_mday(cal_mday), .cal_mon(cal_mon),
    .cal_year(cal_year), .irq_o(irq_o), .cfg_rate(cfg_rate),
    .cfg_per_en(cfg_per_en), .cfg_sqw_en(cfg_sqw_en),
    .cfg_bin_mode(cfg_bin_mode), .cfg_24h(cfg_24h));

  function automatic logic [7:0] exp_ctla_wr(input logic [7:0] v, input logic busy);
    return {busy, v[6:0]};
  endfunction

  function automatic logic [7:0] exp_ctlb_wr(input logic [7:0] v);
    return v[7] ? (v & 8'hEF) : v;
  endfunction

  function automatic bit exp_alarm(input logic [7:0] a, input logic [7:0] t);
    return (a[7:6] == 2'b11) || (a == t);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr_port(input logic s, input logic [7:0] v);
    host_sel = s; host_wr = 1'b1; host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_port(input logic s, output logic [7:0] v);
    host_sel = s; host_rd = 1'b1;
    #1 v = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic reg_wr(input int ix, input logic [7:0] v);
    wr_port(1'b0, 8'(ix));
    wr_port(1'b1, v);
  endtask

  task automatic reg_rd(input int ix, output logic [7:0] v);
    wr_port(1'b0, 8'(ix));
    rd_port(1'b1, v);
  endtask

  task automatic tick_pulse();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < 128; i++) mirror[i] = 8'h00;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    chk("R3 irq", {7'd0, irq_o}, 8'h00);
    reg_rd(10, v); chk("R3 A", v, 8'h26);
    reg_rd(11, v); chk("R3 B", v, 8'h02);
    reg_rd(12, v); chk("R3 C", v, 8'h00);
    reg_rd(13, v); chk("R3 D", v, 8'h80);

    // R1 even read, index bit 7 dropped
    rd_port(1'b0, v); chk("R1 even read", v, 8'hFF);
    reg_wr(14, 8'h5A); mirror[14] = 8'h5A;
    wr_port(1'b0, 8'h8E);
    rd_port(1'b1, v); chk("R1 index 7 bits", v, 8'h5A);

    // R2 random storage traffic
    for (int it = 0; it < 40; it++) begin
      int ix;
      logic [7:0] d;
      case ($urandom_range(0, 3))
        0: ix = 1;
        1: ix = 3;
        2: ix = 5;
        default: ix = $urandom_range(14, 127);
      endcase
      d = 8'($urandom);
      reg_wr(ix, d); mirror[ix] = d;
      if ($urandom_range(0, 3) == 0) begin
        rd_port(1'b0, v); chk("R1 even read rnd", v, 8'hFF);
      end
      ix = ($urandom_range(0, 1) == 0) ? ix : $urandom_range(14, 127);
      reg_rd(ix, v); chk("R2 storage", v, mirror[ix]);
    end

    // R4 read-only parts
    reg_wr(10, 8'hFF); reg_rd(10, v); chk("R4 A busy ro", v, exp_ctla_wr(8'hFF, 1'b0));
    reg_wr(10, 8'h26);
    reg_wr(12, 8'hFF); reg_rd(12, v); chk("R4 C ignores", v, 8'h00);
    chk("R4 irq", {7'd0, irq_o}, 8'h00);
    reg_wr(13, 8'h00); reg_rd(13, v); chk("R4 D ignores", v, 8'h80);

    // R13 config outputs
    reg_wr(10, 8'h2B); reg_wr(11, 8'h0E);
    chk("R13 rate", {4'd0, cfg_rate}, 8'h0B);
    chk("R13 bits", {4'd0, cfg_per_en, cfg_sqw_en, cfg_bin_mode, cfg_24h}, 8'h07);
    reg_wr(10, 8'h26); reg_wr(11, 8'h02);

    // R7 window, R8 copy
    tick_pulse();
    reg_rd(10, v); chk("R7 busy set", v, 8'hA6);
    idle(N + 2);
    reg_rd(10, v); chk("R7 busy clear", v, 8'h26);
    reg_rd(0, v); chk("R8 sec", v, cal_sec);
    reg_rd(2, v); chk("R8 min", v, cal_min);
    reg_rd(4, v); chk("R8 hour", v, cal_hour);
    reg_rd(6, v); chk("R8 wday", v, cal_wday);
    reg_rd(7, v); chk("R8 mday", v, cal_mday);
    reg_rd(8, v); chk("R8 mon", v, cal_mon);
    reg_rd(9, v); chk("R8 year", v, cal_year);
    reg_rd(12, v); chk("R10 no enable", v, 8'h00);

    // R7 oscillator stopped: tick ignored
    cal_sec = 8'h31;
    reg_wr(10, 8'h06);
    tick_pulse();
    reg_rd(10, v); chk("R7 osc off busy", v, 8'h06);
    idle(N + 2);
    reg_rd(0, v); chk("R7 osc off no copy", v, 8'h30);
    reg_wr(10, 8'h26);

    // R6 hold write during window, R8 no copy under hold
    tick_pulse();
    reg_wr(11, 8'h92);
    reg_rd(10, v); chk("R6 busy cleared", v, 8'h26);
    reg_rd(11, v); chk("R6 B stored", v, exp_ctlb_wr(8'h92));
    idle(N + 2);
    reg_rd(0, v); chk("R8 hold no copy", v, 8'h30);
    // R7 tick under hold: busy stays clear
    tick_pulse();
    reg_rd(10, v); chk("R7 hold busy", v, 8'h26);
    idle(N + 2);
    reg_wr(11, 8'h02);

    // R10 update-ended
    reg_wr(11, 8'h12);
    tick_pulse(); idle(N + 2);
    chk("R10 irq", {7'd0, irq_o}, 8'h01);
    reg_rd(12, v); chk("R10 flags", v, 8'h90);
    chk("R5 irq low", {7'd0, irq_o}, 8'h00);
    reg_rd(12, v); chk("R5 cleared", v, 8'h00);

    // R9 alarm: seconds exact, minutes don't care, hours exact
    reg_wr(11, 8'h22);
    reg_wr(1, 8'h31); reg_wr(3, 8'hC0); reg_wr(5, 8'h12);
    tick_pulse(); idle(N + 2);
    v = (exp_alarm(8'h31, cal_sec) && exp_alarm(8'hC0, cal_min) && exp_alarm(8'h12, cal_hour)) ? 8'hA0 : 8'h00;
    reg_rd(12, v); chk("R9 alarm match", v, 8'hA0);
    reg_wr(5, 8'h13);
    tick_pulse(); idle(N + 2);
    chk("R9 no irq", {7'd0, irq_o}, 8'h00);
    reg_rd(12, v); chk("R9 alarm miss", v, 8'h00);
    reg_wr(11, 8'h02);

    // R11 periodic
    per_pulse = 1'b1; @(negedge clk); per_pulse = 1'b0;
    reg_rd(12, v); chk("R11 disabled", v, 8'h00);
    reg_wr(11, 8'h42);
    per_pulse = 1'b1; @(negedge clk); per_pulse = 1'b0;
    chk("R11 irq", {7'd0, irq_o}, 8'h01);
    reg_rd(12, v); chk("R11 flags", v, 8'hC0);

    // R12 event and read-clear in the same cycle
    wr_port(1'b0, 8'd12);
    per_pulse = 1'b1; host_sel = 1'b1; host_rd = 1'b1;
    #1 v = host_rdata;
    @(negedge clk);
    per_pulse = 1'b0; host_rd = 1'b0;
    chk("R12 old value", v, 8'h00);
    chk("R12 irq kept", {7'd0, irq_o}, 8'h01);
    rd_port(1'b1, v); chk("R12 flags kept", v, 8'hC0);
    chk("R5 irq low after", {7'd0, irq_o}, 8'h00);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule